// File: doc/BRIEF.md
# Time-Proportioning Heater Switch Driver

This block drives one on/off output that feeds the control input of a solid-state relay for a resistive heater. The output works as a very slow PWM. Its period is a whole number of seconds, chosen to suit the thermal mass of the oven rather than any electrical time constant. Each window starts with the output high for an on-time and ends with the output low. The on-time in seconds is the duty percent times the window length, divided by 100, using integer arithmetic that truncates.

Time comes from a one-millisecond tick strobe. A parameter sets how many ticks make one second. Duty and window length are sampled only when a window starts, so a window that is running is never cut short or stretched. A force input skips the calculation and holds the output high, which suits full-power ramps. The enable input stops the output and the timing at once.

Top module: `heat_window_drv`

## Requirements
- R1: Within each window the output is high for the first trunc(duty × window / 100) seconds and low for the rest of the window.
- R2: A window lasts the latched window length times TICKS_PER_SEC tick strobes, and the next window begins on the following edge with no gap. A window length of 0 is treated as 1 second.
- R3: While enable and force_full are both high, relay_on is high in the same cycle, whatever the duty and the window position.
- R4: A change to duty_pct or win_sec has no effect on the window that is running. The new values are taken when the next window starts.
- R5: While enable is low, relay_on is low in the same cycle and the timing state is cleared. After enable returns, the first clock edge starts a fresh window with the current inputs.
- R6: A duty of 0 keeps the output low for the whole window. A duty of 100 or more keeps it high for the whole window.
- R7: Window time advances only on clock edges where tick_ms is high. While no tick arrives, the output holds its level.
- R8: During reset and right after it, relay_on is low and no window is running. The first enabled edge after reset starts a window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms | input | 1 | One-millisecond tick strobe, one cycle wide |
| enable | input | 1 | Run control; low forces the output off and clears timing |
| force_full | input | 1 | Full-drive override, bypasses the on-time calculation |
| duty_pct | input | DUTY_W (7) | Duty in percent; values of 100 and above mean full |
| win_sec | input | WIN_W (8) | Window length in seconds; 0 is treated as 1 |
| relay_on | output | 1 | Relay control output |

## Verification
Two events can fall in the same cycle. One is an update to the duty input. The other is the window boundary that decides whether that update is taken. The bench changes the duty from 50 to 100 in the middle of a 4-second window. It then checks that the first window still shows exactly 2 seconds of high output and that the next window is high for all 4 seconds. A second collision is between the enable and the window timing: enable is dropped partway through a window and raised again, and the output must be low at once and then high on the first sample of a new window. Force and a zero duty are applied together to show that the override wins in the same cycle.

// File: rtl/hwd_pkg.sv
package hwd_pkg;
   localparam int unsigned PCT_FULL = 100;

   function automatic int unsigned width_of(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/hwd_tick_div.sv
module hwd_tick_div #(
   parameter int unsigned TICKS_PER_SEC = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic count_en,
   output logic sec_step
);
   localparam int unsigned MS_W = hwd_pkg::width_of(TICKS_PER_SEC);
   localparam logic [MS_W-1:0] MS_LAST = MS_W'(TICKS_PER_SEC - 1);

   logic [MS_W-1:0] ms_cnt;

   generate
      if (TICKS_PER_SEC < 1) begin : g_bad_tps
         $error("TICKS_PER_SEC must be at least 1");
      end
   endgenerate

   assign sec_step = count_en && (ms_cnt == MS_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             ms_cnt <= '0;
      else if (clear)         ms_cnt <= '0;
      else if (sec_step)      ms_cnt <= '0;
      else if (count_en)      ms_cnt <= ms_cnt + 1'b1;
   end

   // R2: the millisecond count never leaves its range
   a_r2_ms_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      ms_cnt <= MS_LAST);

   // R7: without a tick the sub-second count stays where it is
   a_r7_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!count_en && !clear) |=> $stable(ms_cnt));
endmodule

// File: rtl/hwd_ontime.sv
module hwd_ontime #(
   parameter int unsigned DUTY_W = 7,
   parameter int unsigned WIN_W  = 8
) (
   input  logic [DUTY_W-1:0] duty,
   input  logic [WIN_W-1:0]  win,
   output logic [WIN_W-1:0]  on_sec
);
   localparam int unsigned PROD_W = DUTY_W + WIN_W;

   logic [DUTY_W-1:0] duty_eff;
   logic [PROD_W-1:0] prod;

   generate
      if (DUTY_W < 1 || WIN_W < 1) begin : g_bad_w
         $error("DUTY_W and WIN_W must be at least 1");
      end
      if ((1 << DUTY_W) > hwd_pkg::PCT_FULL) begin : g_clamp
         always_comb
            duty_eff = (duty >= DUTY_W'(hwd_pkg::PCT_FULL)) ?
                       DUTY_W'(hwd_pkg::PCT_FULL) : duty;
      end else begin : g_pass
         always_comb duty_eff = duty;
      end
   endgenerate

   always_comb begin
      prod   = PROD_W'(duty_eff) * PROD_W'(win);
      on_sec = WIN_W'(prod / PROD_W'(hwd_pkg::PCT_FULL));
   end

   // R6: the on-time never exceeds the window
   always_comb a_r6_on_within_win: assert (on_sec <= win);
endmodule

// File: rtl/hwd_window_seq.sv
module hwd_window_seq #(
   parameter int unsigned WIN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             sec_step,
   input  logic [WIN_W-1:0] win_in,
   input  logic [WIN_W-1:0] on_in,
   output logic             running,
   output logic [WIN_W-1:0] sec_cnt,
   output logic [WIN_W-1:0] on_q
);
   logic [WIN_W-1:0] win_q;
   logic             wrap;

   assign wrap = sec_step && (sec_cnt == win_q - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         sec_cnt <= '0;
         win_q   <= '0;
         on_q    <= '0;
      end else if (clear) begin
         running <= 1'b0;
         sec_cnt <= '0;
         win_q   <= '0;
         on_q    <= '0;
      end else if (!running || wrap) begin
         running <= 1'b1;
         sec_cnt <= '0;
         win_q   <= win_in;
         on_q    <= on_in;
      end else if (sec_step) begin
         sec_cnt <= sec_cnt + 1'b1;
      end
   end

   // R4: settings stay fixed inside a running window
   a_r4_latch_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !clear && !sec_step) |=> ($stable(on_q) && $stable(win_q)));

   // R2: second count stays inside the latched window
   a_r2_sec_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (sec_cnt < win_q));

   // R5: a disable clears the timing state
   a_r5_clear_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (!running && sec_cnt == '0));
endmodule

// File: rtl/heat_window_drv.sv
module heat_window_drv #(
   parameter int unsigned TICKS_PER_SEC = 1000,
   parameter int unsigned DUTY_W        = 7,
   parameter int unsigned WIN_W         = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_ms,
   input  logic              enable,
   input  logic              force_full,
   input  logic [DUTY_W-1:0] duty_pct,
   input  logic [WIN_W-1:0]  win_sec,
   output logic              relay_on
);
   logic             running;
   logic             sec_step;
   logic [WIN_W-1:0] win_eff;
   logic [WIN_W-1:0] on_calc;
   logic [WIN_W-1:0] sec_cnt;
   logic [WIN_W-1:0] on_q;

   assign win_eff = (win_sec == '0) ? WIN_W'(1) : win_sec;

   hwd_tick_div #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (!enable),
      .count_en (running && tick_ms),
      .sec_step (sec_step)
   );

   hwd_ontime #(.DUTY_W(DUTY_W), .WIN_W(WIN_W)) u_calc (
      .duty   (duty_pct),
      .win    (win_eff),
      .on_sec (on_calc)
   );

   hwd_window_seq #(.WIN_W(WIN_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (!enable),
      .sec_step (sec_step),
      .win_in   (win_eff),
      .on_in    (on_calc),
      .running  (running),
      .sec_cnt  (sec_cnt),
      .on_q     (on_q)
   );

   assign relay_on = enable && (force_full || (running && (sec_cnt < on_q)));

   // R1: a zero on-time never drives the relay without an override
   a_r1_zero_on_low: assert property (@(posedge clk) disable iff (!rst_n)
      (running && on_q == '0 && !force_full) |-> !relay_on);
endmodule

// File: tb/heat_window_drv_bench.sv
module heat_window_drv_bench;
   localparam int T = 10;
   localparam int NV = 8;
   localparam int VD [NV] = '{50, 33, 0, 100, 120, 99, 75, 100};
   localparam int VW [NV] = '{ 3, 10, 5,   4,   2,  1,  4,   0};
   localparam int VE [NV] = '{ 1,  3, 0,   4,   2,  0,  3,   1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_ms = 1'b1;
   logic enable = 1'b0;
   logic force_full = 1'b0;
   logic [6:0] duty_pct = '0;
   logic [7:0] win_sec = '0;
   logic relay_on;
   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   heat_window_drv #(.TICKS_PER_SEC(T)) u_heat_window_drv (
      .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .enable(enable),
      .force_full(force_full), .duty_pct(duty_pct), .win_sec(win_sec),
      .relay_on(relay_on)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic count_high(input int n, output int hi);
      hi = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (relay_on) hi++;
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      int hi;
      // R8: reset state
      enable = 1'b1; duty_pct = 7'd100; win_sec = 8'd2;
      repeat (3) @(negedge clk);
      check("R8 low in reset", int'(relay_on), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 first edge starts window", int'(relay_on), 1);
      enable = 1'b0;
      @(negedge clk);

      // R1 R2 R6 vector table
      for (int v = 0; v < NV; v++) begin
         int we;
         we = (VW[v] == 0) ? 1 : VW[v];
         enable = 1'b0;
         @(negedge clk);
         duty_pct = 7'(VD[v]); win_sec = 8'(VW[v]); enable = 1'b1;
         count_high(we * T, hi);
         check($sformatf("R1 R6 vector %0d high cycles", v), hi, VE[v] * T);
         @(negedge clk);
         check($sformatf("R2 vector %0d next window start", v),
               int'(relay_on), (VE[v] > 0) ? 1 : 0);
      end

      // R4: duty change mid-window waits for the boundary
      enable = 1'b0;
      @(negedge clk);
      duty_pct = 7'd50; win_sec = 8'd4; enable = 1'b1;
      count_high(T, hi);
      duty_pct = 7'd100;
      begin
         int hi2;
         count_high(3 * T, hi2);
         check("R4 old duty kept in window", hi + hi2, 2 * T);
      end
      count_high(4 * T, hi);
      check("R4 new duty at next window", hi, 4 * T);

      // R7: no tick, no progress
      enable = 1'b0;
      @(negedge clk);
      duty_pct = 7'd50; win_sec = 8'd2; tick_ms = 1'b0; enable = 1'b1;
      repeat (5 * T) @(negedge clk);
      check("R7 holds without tick", int'(relay_on), 1);
      tick_ms = 1'b1;
      count_high(2 * T, hi);
      check("R7 resumes with tick", hi, T);

      // R5: disable mid-window, then re-enable
      enable = 1'b0;
      @(negedge clk);
      duty_pct = 7'd25; win_sec = 8'd4; enable = 1'b1;
      count_high(15, hi);
      check("R5 low after on-time", int'(relay_on), 0);
      enable = 1'b0;
      #1;
      check("R5 low while disabled", int'(relay_on), 0);
      @(negedge clk);
      enable = 1'b1;
      @(negedge clk);
      check("R5 fresh window on re-enable", int'(relay_on), 1);

      // R3: force overrides zero duty at once
      enable = 1'b0;
      @(negedge clk);
      duty_pct = 7'd0; win_sec = 8'd3; enable = 1'b1;
      @(negedge clk);
      check("R3 zero duty low", int'(relay_on), 0);
      force_full = 1'b1;
      #1;
      check("R3 force high same cycle", int'(relay_on), 1);
      count_high(3 * T, hi);
      check("R3 force high whole window", hi, 3 * T);
      enable = 1'b0;
      #1;
      check("R5 disable beats force", int'(relay_on), 0);
      force_full = 1'b0;

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule